// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block is a small fully associative cache of page translations. It sits between a processor request port and the memory system. Each request carries a virtual address, an access kind (read, write or instruction fetch) and a flag that says whether the requester runs in user mode. On a hit, the block answers one cycle later. The answer is either the physical address or a fault with a cause code.

Pages are 4 KiB. The low twelve address bits pass straight through, and the upper bits form the page number that is used as the lookup key. Every cached entry keeps the frame number next to four permission flags: present, user-accessible, writable and executable. Each hit is therefore checked against the access kind and the privilege mode without touching memory.

On a miss, the request port stalls and the page number is handed to an external table walker. The returned entry is written into the slot picked by a round-robin pointer, and the held request is looked up again. Software can drop a single page from the cache, which is used for shootdown after a permission is revoked. It can also drop every page at once.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no response and no walk request are raised, and every slot is empty, so the first access to any page causes a walk.
- R2: A request is accepted in the cycle it is granted. Its response appears in the next cycle. A non-faulting response carries the cached frame number in bits 31:12 and the request's own bits 11:0 unchanged.
- R3: On a miss the grant stays low and a walk request is raised with the page number (address bits 31:12). Both are held until the walker acknowledges. The returned entry is installed on the acknowledge edge, and the held request is looked up again in the following cycle.
- R4: A hit on an entry whose present flag is 0 faults with cause 1.
- R5: A user-mode access (user flag 1) to a page whose user flag is 0 faults with cause 2. A supervisor access to such a page is allowed.
- R6: A write (access code 1) to a page whose write flag is 0 faults with cause 3.
- R7: An instruction fetch (access code 2) from a page whose execute flag is 0 faults with cause 4. A read uses access code 0.
- R8: When several checks fail, the lowest cause number wins, in the order 1, 2, 3, 4. A faulting response raises the fault flag, drives a physical address of zero and carries a non-zero cause. A clean response has cause 0.
- R9: Fills go to slots 0, 1, …, N-1 in turn and then wrap to slot 0, regardless of whether the victim slot holds a valid entry. With 8 slots, the page filled eight fills earlier is evicted.
- R10: A single-page flush invalidates the matching entry. The next access to that page walks again and is checked against the new permissions. Entries for other pages stay cached. No request is granted in a flush cycle.
- R11: A flush-all clears every slot in one cycle and takes priority over a lookup in the same cycle, so the grant is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until granted |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_grant | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | 0 none, 1 absent, 2 privilege, 3 write, 4 execute |
| walk_req | output | 1 | Table walk wanted |
| walk_vpn | output | 20 | Page number to walk |
| walk_ack | input | 1 | Walker returns the entry this cycle |
| walk_pfn | input | 20 | Returned frame number |
| walk_present | input | 1 | Returned present flag |
| walk_user | input | 1 | Returned user-accessible flag |
| walk_write | input | 1 | Returned writable flag |
| walk_exec | input | 1 | Returned executable flag |
| flush_one | input | 1 | Invalidate the page given by flush_vpn |
| flush_vpn | input | 20 | Page number to invalidate |
| flush_all | input | 1 | Invalidate every slot |

## Verification
The bench covers each fault cause on its own, then pages where several checks fail together, so that a wrong priority order shows up as the wrong cause code. It changes a table entry while the old copy is still cached. This shows that the stale entry is used until a single-page flush, and that the walk after the flush applies the revoked write permission; a design that compared the flush page against the wrong bits would keep the stale grant. Evictions are probed after the pointer wraps past a slot that a flush emptied: a design that reused empty slots first, or that advanced the pointer on the wrong event, evicts a different page and the walk count shows it. A request raised in the same cycle as a flush-all must not be granted. A design that let the lookup win would answer from a cleared entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_PRIV   = 3'd2,
    CAUSE_WRITE  = 3'd3,
    CAUSE_EXEC   = 3'd4
  } cause_e;

  typedef struct packed {
    logic present;
    logic user;
    logic write;
    logic exec;
  } perm_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PFN_W-1:0] look_pfn,
  output perm_t            look_perm,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  perm_t            fill_perm
);

  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]   pfn_arr  [ENTRIES];
  perm_t              perm_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             vld_q, vld_d;
    logic [VPN_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    perm_t            perm_q;
    logic             fill_here;
    logic             data_en;

    assign fill_here = fill_en && (fill_idx == IDX_W'(g));
    assign data_en   = fill_here && !inv_all;

    // next-state of the valid flag: flush-all, then fill, then single flush
    always_comb begin
      vld_d = vld_q;
      if (inv_all) begin
        vld_d = 1'b0;
      end else if (fill_here) begin
        vld_d = 1'b1;
      end else if (inv_one && vld_q && (tag_q == inv_vpn)) begin
        vld_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    // payload registers carry no reset; the valid flag guards them
    always_ff @(posedge clk) begin
      if (data_en) begin
        tag_q  <= fill_vpn;
        pfn_q  <= fill_pfn;
        perm_q <= fill_perm;
      end
    end

    assign match[g]    = vld_q && (tag_q == look_vpn);
    assign pfn_arr[g]  = pfn_q;
    assign perm_arr[g] = perm_q;
  end

  assign look_hit = |match;

  // at most one slot matches, since fills only happen after a miss
  always_comb begin
    look_pfn  = '0;
    look_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        look_pfn  = pfn_arr[i];
        look_perm = perm_arr[i];
      end
    end
  end

endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  perm_t       perm,
  input  logic [1:0]  acc,
  input  logic        user,
  output logic        fault,
  output logic [2:0]  cause
);

  acc_e   kind;
  cause_e why;

  assign kind = acc_e'(acc);

  // lower cause number wins; the reserved access code behaves as a read
  always_comb begin
    why = CAUSE_NONE;
    if (!perm.present) begin
      why = CAUSE_ABSENT;
    end else if (user && !perm.user) begin
      why = CAUSE_PRIV;
    end else if ((kind == ACC_WRITE) && !perm.write) begin
      why = CAUSE_WRITE;
    end else if ((kind == ACC_FETCH) && !perm.exec) begin
      why = CAUSE_EXEC;
    end
  end

  assign cause = why;
  assign fault = (why != CAUSE_NONE);

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             hit,
  input  logic             flush_busy,
  input  logic             walk_ack,
  output logic             grant,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             fill_en,
  output logic [IDX_W-1:0] fill_idx
);

  typedef enum logic {ST_LOOK = 1'b0, ST_WALK = 1'b1} st_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  st_e              st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] rr_q, rr_d;
  logic             start_walk;
  logic             look_ok;

  assign look_ok    = (st_q == ST_LOOK) && req_valid && !flush_busy;
  assign grant      = look_ok && hit;
  assign start_walk = look_ok && !hit;
  assign fill_en    = (st_q == ST_WALK) && walk_ack;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_LOOK: if (start_walk) st_d = ST_WALK;
      ST_WALK: if (walk_ack)   st_d = ST_LOOK;
      default: st_d = ST_LOOK;
    endcase
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_en) begin
      rr_d = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_LOOK;
      rr_q <= '0;
    end else begin
      st_q <= st_d;
      rr_q <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_walk) begin
      vpn_q <= req_vpn;
    end
  end

  assign walk_req = (st_q == ST_WALK);
  assign walk_vpn = vpn_q;
  assign fill_idx = rr_q;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  output logic             req_grant,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [2:0]       rsp_cause,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_ack,
  input  logic [PFN_W-1:0] walk_pfn,
  input  logic             walk_present,
  input  logic             walk_user,
  input  logic             walk_write,
  input  logic             walk_exec,
  input  logic             flush_one,
  input  logic [VPN_W-1:0] flush_vpn,
  input  logic             flush_all
);

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             hit;
  logic [PFN_W-1:0] hit_pfn;
  perm_t            hit_perm;
  perm_t            new_perm;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic             chk_fault;
  logic [2:0]       chk_cause;
  logic             grant;
  logic             vld_q;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             flt_q;
  logic [2:0]       cause_q;

  assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
  assign req_off  = req_vaddr[OFF_W-1:0];
  assign new_perm = '{present: walk_present, user: walk_user,
                      write: walk_write, exec: walk_exec};

  tlb_store #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (req_vpn),
    .look_hit  (hit),
    .look_pfn  (hit_pfn),
    .look_perm (hit_perm),
    .inv_all   (flush_all),
    .inv_one   (flush_one),
    .inv_vpn   (flush_vpn),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_vpn  (walk_vpn),
    .fill_pfn  (walk_pfn),
    .fill_perm (new_perm)
  );

  tlb_perm_chk u_chk_perm (
    .perm  (hit_perm),
    .acc   (req_acc),
    .user  (req_user),
    .fault (chk_fault),
    .cause (chk_cause)
  );

  tlb_ctrl #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vpn    (req_vpn),
    .hit        (hit),
    .flush_busy (flush_all || flush_one),
    .walk_ack   (walk_ack),
    .grant      (grant),
    .walk_req   (walk_req),
    .walk_vpn   (walk_vpn),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx)
  );

  assign pa_d = chk_fault ? '0 : {hit_pfn, req_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= grant;
    end
  end

  always_ff @(posedge clk) begin
    if (grant) begin
      pa_q    <= pa_d;
      flt_q   <= chk_fault;
      cause_q <= chk_cause;
    end
  end

  assign req_grant = grant;
  assign rsp_valid = vld_q;
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;
  assign rsp_cause = cause_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_grant,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_fault,
  input logic [2:0]       rsp_cause,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             walk_ack,
  input logic             flush_one,
  input logic             flush_all
);

  p_rsp_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grant) |=> rsp_valid);

  p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_grant) |=> !rsp_valid);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_walk_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_grant);

  p_walk_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

  p_fault_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != 3'd0));

  p_clean_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_cause == 3'd0));

  p_cause_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cause <= 3'd4));

  p_one_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_one |-> !req_grant);

  p_all_flush_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> !req_grant);

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W)
) u_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_grant (req_grant),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .walk_req  (walk_req),
  .walk_vpn  (walk_vpn),
  .walk_ack  (walk_ack),
  .flush_one (flush_one),
  .flush_all (flush_all)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        req_grant;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_ack = 1'b0;
  logic [19:0] walk_pfn = '0;
  logic        walk_present = 1'b0;
  logic        walk_user = 1'b0;
  logic        walk_write = 1'b0;
  logic        walk_exec = 1'b0;
  logic        flush_one = 1'b0;
  logic [19:0] flush_vpn = '0;
  logic        flush_all = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_acc      (req_acc),
    .req_user     (req_user),
    .req_grant    (req_grant),
    .rsp_valid    (rsp_valid),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .rsp_cause    (rsp_cause),
    .walk_req     (walk_req),
    .walk_vpn     (walk_vpn),
    .walk_ack     (walk_ack),
    .walk_pfn     (walk_pfn),
    .walk_present (walk_present),
    .walk_user    (walk_user),
    .walk_write   (walk_write),
    .walk_exec    (walk_exec),
    .flush_one    (flush_one),
    .flush_vpn    (flush_vpn),
    .flush_all    (flush_all)
  );

  typedef struct packed {
    logic [19:0] pfn;
    logic        p;
    logic        u;
    logic        w;
    logic        x;
  } pte_t;

  typedef struct {
    logic [31:0] paddr;
    logic        fault;
    logic [2:0]  cause;
    string       tag;
  } exp_t;

  pte_t pt [int];
  exp_t sb [$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   n_walks = 0;

  localparam logic [1:0] RD = 2'd0;
  localparam logic [1:0] WR = 2'd1;
  localparam logic [1:0] FE = 2'd2;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endfunction

  // walker model: answers each walk two cycles after it is seen
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && walk_req) begin
        n_walks++;
        if (!pt.exists(int'(walk_vpn))) begin
          chk(1'b0, "R3", "walk for unknown page", 32'(walk_vpn), 32'h0);
        end else begin
          pte_t e;
          logic [19:0] v0;
          e  = pt[int'(walk_vpn)];
          v0 = walk_vpn;
          repeat (2) @(negedge clk);
          chk(walk_req && !req_grant && walk_vpn == v0, "R3", "walk held, grant low",
              {11'h0, walk_req, walk_vpn}, {12'h001, v0});
          walk_ack     = 1'b1;
          walk_pfn     = e.pfn;
          walk_present = e.p;
          walk_user    = e.u;
          walk_write   = e.w;
          walk_exec    = e.x;
          @(negedge clk);
          walk_ack = 1'b0;
        end
      end
    end
  end

  // monitor: pops the scoreboard as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "response with nothing expected", rsp_paddr, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_paddr == e.paddr, e.tag, "paddr", rsp_paddr, e.paddr);
          chk(rsp_cause == e.cause, e.tag, "cause", 32'(rsp_cause), 32'(e.cause));
          chk(rsp_fault == e.fault, e.tag, "fault flag", 32'(rsp_fault), 32'(e.fault));
        end
      end
    end
  end

  // driver: issues one access, pushes the expected response, checks walk count
  task automatic access(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input int exp_walks, input logic [2:0] exp_cause, input string tag);
    int   w0;
    exp_t e;
    @(negedge clk);
    w0        = n_walks;
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = acc;
    req_user  = usr;
    #1;
    while (!req_grant) begin
      @(negedge clk);
      #1;
    end
    e.cause = exp_cause;
    e.fault = (exp_cause != 3'd0);
    e.paddr = e.fault ? 32'h0 : {pt[int'(va[31:12])].pfn, va[11:0]};
    e.tag   = tag;
    sb.push_back(e);
    chk((n_walks - w0) == exp_walks, tag, "walk count", 32'(n_walks - w0), 32'(exp_walks));
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic flush_page(input logic [19:0] vpn);
    @(negedge clk);
    flush_one = 1'b1;
    flush_vpn = vpn;
    @(negedge clk);
    flush_one = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    chk(1'b0, "R3", "timeout", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    pt[32'h10] = '{pfn: 20'h0ABCD, p: 1'b1, u: 1'b1, w: 1'b1, x: 1'b1};
    pt[32'h20] = '{pfn: 20'h11111, p: 1'b1, u: 1'b1, w: 1'b1, x: 1'b0};
    pt[32'h30] = '{pfn: 20'h22222, p: 1'b1, u: 1'b1, w: 1'b0, x: 1'b1};
    pt[32'h40] = '{pfn: 20'h33333, p: 1'b1, u: 1'b0, w: 1'b1, x: 1'b1};
    pt[32'h50] = '{pfn: 20'h44444, p: 1'b0, u: 1'b1, w: 1'b1, x: 1'b1};
    pt[32'h60] = '{pfn: 20'h55555, p: 1'b1, u: 1'b0, w: 1'b0, x: 1'b0};
    pt[32'h70] = '{pfn: 20'h66666, p: 1'b0, u: 1'b0, w: 1'b0, x: 1'b0};
    pt[32'h80] = '{pfn: 20'h77777, p: 1'b1, u: 1'b1, w: 1'b1, x: 1'b1};
    pt[32'h90] = '{pfn: 20'h88888, p: 1'b1, u: 1'b1, w: 1'b1, x: 1'b1};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'h0);
    chk(walk_req == 1'b0, "R1", "no walk after reset", 32'(walk_req), 32'h0);

    // first touch walks (R1), then hits with offsets intact (R2)
    access(32'h0001_0123, RD, 1'b1, 1, 3'd0, "R1");
    access(32'h0001_0FFF, WR, 1'b1, 0, 3'd0, "R2");
    access(32'h0001_0000, FE, 1'b1, 0, 3'd0, "R2");

    // single causes
    access(32'h0002_0400, FE, 1'b1, 1, 3'd4, "R7");
    access(32'h0002_0404, RD, 1'b1, 0, 3'd0, "R7");
    access(32'h0003_0008, WR, 1'b1, 1, 3'd3, "R6");
    access(32'h0003_0008, FE, 1'b1, 0, 3'd0, "R6");
    access(32'h0004_0010, RD, 1'b1, 1, 3'd2, "R5");
    access(32'h0004_0010, RD, 1'b0, 0, 3'd0, "R5");
    access(32'h0004_0A10, WR, 1'b0, 0, 3'd0, "R5");
    access(32'h0005_0020, RD, 1'b1, 1, 3'd1, "R4");
    access(32'h0005_0020, RD, 1'b0, 0, 3'd1, "R4");

    // several checks failing at once
    access(32'h0006_0030, WR, 1'b1, 1, 3'd2, "R8");
    access(32'h0006_0030, WR, 1'b0, 0, 3'd3, "R8");
    access(32'h0006_0030, FE, 1'b0, 0, 3'd4, "R8");
    access(32'h0006_0030, RD, 1'b0, 0, 3'd0, "R8");
    access(32'h0007_0040, WR, 1'b1, 1, 3'd1, "R8");

    // revoke write on page 0x10: stale until flushed (R10)
    pt[32'h10] = '{pfn: 20'h0ABCD, p: 1'b1, u: 1'b1, w: 1'b0, x: 1'b1};
    access(32'h0001_0050, WR, 1'b1, 0, 3'd0, "R10");
    flush_page(20'h10);
    access(32'h0001_0050, WR, 1'b1, 1, 3'd3, "R10");
    flush_page(20'h99);
    access(32'h0004_0010, RD, 1'b0, 0, 3'd0, "R10");

    // round-robin: slots 0..7 filled in turn, pointer now back at 0 (R9)
    access(32'h0008_0001, RD, 1'b1, 1, 3'd0, "R9");
    access(32'h0009_0002, RD, 1'b1, 1, 3'd0, "R9");
    access(32'h0003_0003, FE, 1'b1, 0, 3'd0, "R9");
    access(32'h0002_0004, RD, 1'b1, 1, 3'd0, "R9");
    access(32'h0003_0005, FE, 1'b1, 1, 3'd0, "R9");
    access(32'h0004_0006, RD, 1'b0, 1, 3'd0, "R9");

    // flush-all beats a same-cycle lookup (R11)
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0008_0100;
    req_acc   = RD;
    req_user  = 1'b1;
    flush_all = 1'b1;
    #1;
    chk(req_grant == 1'b0, "R11", "grant during flush-all", 32'(req_grant), 32'h0);
    @(negedge clk);
    flush_all = 1'b0;
    req_valid = 1'b0;
    access(32'h0008_0100, RD, 1'b1, 1, 3'd0, "R11");
    access(32'h0001_0200, WR, 1'b1, 1, 3'd3, "R11");

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R2", "responses outstanding", 32'(sb.size()), 32'h0);
    report();
    $finish;
  end

endmodule